// File: doc/BRIEF.md
# Three-Source Masked Interrupt Aggregator

This block gathers three interrupt sources of a register-mapped peripheral into a single level-sensitive interrupt line. Each source event arrives as a one-cycle pulse and is held in a sticky status bit until software clears it. Software clears a status bit by writing 1 to it.

A mask register decides which held events reach the interrupt line. Software cannot write the mask directly. It changes only through two write-only ports: the enable port clears mask bits, and the disable port sets them. A third write-only port lets software raise any status bit, which is useful for testing interrupt paths.

Register access uses a simple write strobe with address and data, plus a separate read address with combinational read data. All registers are 32 bits wide and live at word-aligned byte offsets. Only the low three bits of each register carry state.

Top module: `irq_agg`

## Requirements
- R1: After reset the status register reads 0x0, the mask register reads 0x7 (all sources masked), and `irq` is low.
- R2: A pulse on `src_evt[i]` sets status bit i, and that bit stays set after the pulse ends. Bit 2 is data ready, bit 1 is abort, and bit 0 is invalid bus access.
- R3: Writing the status register (offset 0x00) clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If a source pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Writes to the mask register (offset 0x04) have no effect on the mask.
- R6: Writing the enable port (offset 0x08) clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R7: Writing the disable port (offset 0x0C) sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R8: Writing the trigger port (offset 0x10) sets each status bit written as 1 and leaves the other status bits unchanged.
- R9: `irq` is high exactly when some status bit is set and its mask bit is 0.
- R10: Reads of the enable, disable and trigger ports, and reads of any unmapped offset, return 0.
- R11: Bits 31:3 of every register read as 0, and writing 1s to them changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| src_evt | input | 3 | One-cycle source event pulses |
| irq | output | 1 | Level interrupt output |

## Verification
A write or a source pulse that is present at a rising edge changes the status and mask registers at that same edge. `irq` and `rd_data` are combinational from those registers, so both show the new value right after that edge, with no further delay. The bench drives inputs at falling edges. It samples results at the following falling edge, half a cycle after the capturing edge, and allows a one-unit settle delay after changing the read address. For the same-cycle race in R4, the pulse and the clear are driven together in one cycle, and the bit is read at the next falling edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NSRC = 3;

    // Source bit positions; software decodes these.
    localparam int SRC_BADACC = 0;
    localparam int SRC_ABORT  = 1;
    localparam int SRC_READY  = 2;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_MASK,
        SEL_UNMASK,
        SEL_SETMASK,
        SEL_FORCE,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic status;
        logic mask;
        logic unmask;
        logic setmask;
        logic force_set;
    } wr_strobe_t;

    function automatic reg_sel_e addr_to_sel(input logic [7:0] a);
        case (a)
            8'h00:   return SEL_STATUS;
            8'h04:   return SEL_MASK;
            8'h08:   return SEL_UNMASK;
            8'h0C:   return SEL_SETMASK;
            8'h10:   return SEL_FORCE;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    output wr_strobe_t    strobe
);
    reg_sel_e sel;

    always_comb begin
        sel    = addr_to_sel(8'(wr_addr));
        strobe = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_STATUS:  strobe.status    = 1'b1;
                SEL_MASK:    strobe.mask      = 1'b1;
                SEL_UNMASK:  strobe.unmask    = 1'b1;
                SEL_SETMASK: strobe.setmask   = 1'b1;
                SEL_FORCE:   strobe.force_set = 1'b1;
                default:     strobe           = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_agg_status_reg.sv
module irq_agg_status_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic         set_we,
    input  logic [N-1:0] bits,
    input  logic [N-1:0] evt,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic set_i;
        logic clr_i;
        assign set_i = evt[i] | (set_we & bits[i]);
        assign clr_i = clr_we & bits[i];

        // set takes priority over clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     status[i] <= 1'b0;
            else if (set_i) status[i] <= 1'b1;
            else if (clr_i) status[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_agg_mask_reg.sv
module irq_agg_mask_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         unmask_we,
    input  logic         setmask_we,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mask <= '1;
        else if (unmask_we)  mask <= mask & ~bits;
        else if (setmask_we) mask <= mask | bits;
    end
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
    import irq_agg_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int N  = 3
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [N-1:0]  status,
    input  logic [N-1:0]  mask,
    output logic [DW-1:0] rd_data
);
    localparam int PAD = DW - N;

    always_comb begin
        unique case (addr_to_sel(8'(rd_addr)))
            SEL_STATUS: rd_data = {{PAD{1'b0}}, status};
            SEL_MASK:   rd_data = {{PAD{1'b0}}, mask};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [NSRC-1:0] src_evt,
    output logic          irq
);
    wr_strobe_t      strobe;
    logic [NSRC-1:0] wbits;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;

    // reserved upper write bits are dropped here (R11)
    assign wbits = wr_data[NSRC-1:0];

    irq_agg_decode #(.AW(AW)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .strobe  (strobe)
    );

    irq_agg_status_reg #(.N(NSRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_we (strobe.status),
        .set_we (strobe.force_set),
        .bits   (wbits),
        .evt    (src_evt),
        .status (status_q)
    );

    irq_agg_mask_reg #(.N(NSRC)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .unmask_we  (strobe.unmask),
        .setmask_we (strobe.setmask),
        .bits       (wbits),
        .mask       (mask_q)
    );

    irq_agg_rdmux #(.AW(AW), .DW(DW), .N(NSRC)) u_rd (
        .rd_addr (rd_addr),
        .status  (status_q),
        .mask    (mask_q),
        .rd_data (rd_data)
    );

    assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [DW-1:0]   wr_data,
    input logic [DW-1:0]   rd_data,
    input logic [NSRC-1:0] src_evt,
    input logic [NSRC-1:0] status,
    input logic [NSRC-1:0] mask
);
    logic w_status, w_mask, w_unmask, w_setmask, w_force;
    assign w_status  = wr_en && addr_to_sel(8'(wr_addr)) == SEL_STATUS;
    assign w_mask    = wr_en && addr_to_sel(8'(wr_addr)) == SEL_MASK;
    assign w_unmask  = wr_en && addr_to_sel(8'(wr_addr)) == SEL_UNMASK;
    assign w_setmask = wr_en && addr_to_sel(8'(wr_addr)) == SEL_SETMASK;
    assign w_force   = wr_en && addr_to_sel(8'(wr_addr)) == SEL_FORCE;

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((status & $past(src_evt)) == $past(src_evt)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_status && (src_evt & wr_data[NSRC-1:0]) == '0)
        |=> ((status & $past(wr_data[NSRC-1:0])) == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_status && (src_evt & wr_data[NSRC-1:0]) != '0)
        |=> ((status & $past(src_evt)) == $past(src_evt)));

    p_mask_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        w_mask |=> $stable(mask));

    p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w_unmask |=> ((mask & $past(wr_data[NSRC-1:0])) == '0));

    p_setmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        w_setmask |=> ((mask & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));

    p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        w_force |=> ((status & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:NSRC] == '0);
endmodule

bind irq_agg irq_agg_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .src_evt (src_evt),
    .status  (status_q),
    .mask    (mask_q)
);

// File: tb/tb_irq_agg.sv
module tb_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  src_evt = '0;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;  // 250 MHz

    irq_agg dut (.*);

    localparam logic [7:0] A_ST = 8'h00, A_MK = 8'h04, A_EN = 8'h08,
                           A_DS = 8'h0C, A_TR = 8'h10;

    // {is_event, addr, data, exp_status, exp_mask, exp_irq, req}
    typedef struct packed {
        logic        ev;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [2:0]  st;
        logic [2:0]  mk;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, A_EN, 32'h4,        3'h0, 3'h3, 1'b0, 4'd6},  // R6 unmask ready
        '{1'b1, 8'h0, 32'h4,        3'h4, 3'h3, 1'b1, 4'd2},  // R2 ready event, R9
        '{1'b1, 8'h0, 32'h1,        3'h5, 3'h3, 1'b1, 4'd2},  // R2 bad access event
        '{1'b0, A_MK, 32'h0,        3'h5, 3'h3, 1'b1, 4'd5},  // R5 mask write ignored
        '{1'b0, A_DS, 32'h4,        3'h5, 3'h7, 1'b0, 4'd7},  // R7 remask, R9 low
        '{1'b0, A_ST, 32'h1,        3'h4, 3'h7, 1'b0, 4'd3},  // R3 clear bit0 only
        '{1'b0, A_TR, 32'h2,        3'h6, 3'h7, 1'b0, 4'd8},  // R8 force abort
        '{1'b0, A_EN, 32'h3,        3'h6, 3'h4, 1'b1, 4'd6},  // R6, R9 high
        '{1'b0, A_ST, 32'h2,        3'h4, 3'h4, 1'b0, 4'd3},  // R3 clear abort
        '{1'b0, A_TR, 32'hFFFFFFF9, 3'h5, 3'h4, 1'b1, 4'd11}, // R11 reserved ignored
        '{1'b0, A_DS, 32'hFFFFFFFF, 3'h5, 3'h7, 1'b0, 4'd7},  // R7 mask all
        '{1'b0, A_ST, 32'h7,        3'h0, 3'h7, 1'b0, 4'd3}   // R3 clear all
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_evt(input logic [2:0] v);
        @(negedge clk);
        src_evt = v;
        @(negedge clk);
        src_evt = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, checked while reset is still low and after release
        rd_chk("R1 status", A_ST, 32'h0);
        rd_chk("R1 mask", A_MK, 32'h7);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 mask after release", A_MK, 32'h7);

        foreach (VEC[i]) begin
            if (VEC[i].ev) do_evt(VEC[i].data[2:0]);
            else           do_wr(VEC[i].addr, VEC[i].data);
            rd_chk($sformatf("R%0d vec%0d status", VEC[i].req, i), A_ST, {29'b0, VEC[i].st});
            rd_chk($sformatf("R%0d vec%0d mask", VEC[i].req, i), A_MK, {29'b0, VEC[i].mk});
            check($sformatf("R9 vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i].irq});
        end

        // R10 write-only ports and unmapped offsets read 0
        do_wr(A_TR, 32'h7);
        rd_chk("R10 enable port", A_EN, 32'h0);
        rd_chk("R10 disable port", A_DS, 32'h0);
        rd_chk("R10 trigger port", A_TR, 32'h0);
        rd_chk("R10 unmapped", 8'h40, 32'h0);
        rd_chk("R11 status upper zero", A_ST, 32'h7);

        // R4 same-cycle event and clear on abort bit: set wins; bit0 clears
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_ST; wr_data = 32'h3; src_evt = 3'b010;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; src_evt = '0;
        rd_chk("R4 set wins", A_ST, 32'h6);

        // R9 single source reaches irq only when unmasked
        do_wr(A_ST, 32'h7);
        do_evt(3'b010);
        check("R9 masked abort", {31'b0, irq}, 32'h0);
        do_wr(A_EN, 32'h2);
        check("R9 unmasked abort", {31'b0, irq}, 32'h1);

        // R11 reserved bits on enable port do not disturb mask
        do_wr(A_EN, 32'hFFFFFFF8);
        rd_chk("R11 enable reserved", A_MK, 32'h5);

        // R1 reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        rd_chk("R1 re-reset status", A_ST, 32'h0);
        rd_chk("R1 re-reset mask", A_MK, 32'h7);
        check("R1 re-reset irq", {31'b0, irq}, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule